// File: doc/BRIEF.md
# Register-Mapped Time-of-Day Counter with Alarm

This block keeps the time of day for a chip that runs from a slow reference oscillator. A prescaler divides the reference down to one tick per second, and a chain of counters holds seconds, minutes, hours and a 9-bit day number. An alarm set of registers (day, hour, minute, second) is compared against the live count. When a second tick makes the two equal, the block produces a one-cycle alarm pulse and latches an alarm flag in a status register.

Software reaches every register through a plain 16-bit register port: byte offset, write strobe, write data, and a combinational read-data return. The port has no handshake, because every access completes in one cycle. The status and interrupt-enable words are driven out as pins. A companion interrupt block masks the status with the enable word and also uses the per-second pulse.

The prescale divisors for the three reference choices are parameters. The defaults are 32768, 32000 and 38400 cycles per second.

Top module: `rtk_top`

## Requirements
- R1: After reset, every register reads 0, and `sec_tick` and `alarm_hit` are low.
- R2: Time, alarm and interrupt-enable registers read back exactly what was last written, as long as no tick intervenes.
  - Time registers: hour/minute at 0x00, seconds at 0x04, day at 0x20.
  - Alarm registers: hour/minute at 0x08, seconds at 0x0C, day at 0x24.
  - Field layout: an hour/minute word holds a 5-bit hour in bits 12:8 and a 6-bit minute in bits 5:0. Seconds sit in bits 5:0. The day sits in bits 8:0.
  - Interrupt enable (0x18) keeps all 16 bits and drives `irq_enable`.
  - Offsets that are not mapped read 0, and writes to them change no register.
- R3: The control word at 0x10 holds the module enable in bit 7 and a reference select in bits 6:5. It reads back these three bits, with all other bits 0.
- R4: With the block enabled, one second lasts DIV_A cycles for select 00, DIV_B for 01, DIV_C for 10, and DIV_A for 11.
- R5: A tick advances the counters with carries:
  - a seconds value of 59 or more becomes 0 and carries into minutes;
  - a minutes value of 59 or more becomes 0 and carries into hours;
  - an hours value of 23 or more becomes 0 and carries into the day;
  - the day wraps from 511 to 0.
- R6: While the enable bit is 0, the counters and the prescaler hold, with the prescaler held at zero. The first second after enabling therefore lasts a full period, counted from the enabling write.
- R7: Writing any time register clears the prescaler and suppresses a tick in that cycle. The next second lasts a full period from the write.
- R8: `alarm_hit` is a one-cycle pulse in the cycle after a tick, raised only when the new day, hour, minute and second all equal the alarm registers. Making the time equal to the alarm by a write gives no pulse.
- R9: The status word at 0x14 sets bit 2 on an alarm pulse and bit 4 on every second. Writing a 1 to a bit clears it. If a set and a clear fall in the same cycle, the set wins. The word drives `irq_status`.
- R10: `sec_tick` pulses for one cycle once per second. It is high in the first cycle in which the advanced time can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| sec_tick | output | 1 | One-cycle pulse per second |
| alarm_hit | output | 1 | One-cycle alarm match pulse |
| irq_status | output | 16 | Status flags (bit 2 alarm, bit 4 second) |
| irq_enable | output | 16 | Interrupt enable word |

## Verification
On every cycle, the assertions check the following:
- the time is stable whenever there is neither a tick nor a time write;
- seconds wrap after 59;
- ticks appear only while the block is enabled, and never during a time write;
- an alarm pulse follows a tick and lasts one cycle;
- the status alarm flag rises only after a pulse;
- the enable bit follows a control write.

Only the bench's scenarios can show the exact period for each reference select and the full carry chain through the day wrap. They also show that a time write restarts the second, that an alarm fires exactly once at the right count, and that status clearing is selective.

// File: rtl/rtk_pkg.sv
package rtk_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFF_HM     = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC    = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_AHM    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_ASEC   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_DAY    = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ADAY   = 6'h24;

  localparam int CTL_EN_BIT    = 7;
  localparam int CTL_SEL_LSB   = 5;
  localparam int ST_ALARM_BIT  = 2;
  localparam int ST_SEC_BIT    = 4;

  typedef struct packed {
    logic [8:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;
endpackage

// File: rtl/rtk_prescale.sv
module rtk_prescale #(
  parameter int DIV_A = 32768,
  parameter int DIV_B = 32000,
  parameter int DIV_C = 38400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       clr,
  output logic       tick
);
  localparam int MAXAB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int MAXD  = (MAXAB > DIV_C) ? MAXAB : DIV_C;
  localparam int CW    = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LIM_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LIM_B = CW'(DIV_B - 1);
  localparam logic [CW-1:0] LIM_C = CW'(DIV_C - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (sel)
      2'b01:   lim = LIM_B;
      2'b10:   lim = LIM_C;
      default: lim = LIM_A;
    endcase
  end

  assign tick = en && !clr && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!en || clr || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtk_counters.sv
module rtk_counters
  import rtk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_hm,
  input  logic        wr_sec,
  input  logic        wr_day,
  input  logic [15:0] wdata,
  output tod_t        now
);
  logic sec_c, min_c, hour_c;
  tod_t nxt;

  always_comb begin
    sec_c  = (now.sec >= 6'd59);
    min_c  = sec_c && (now.min >= 6'd59);
    hour_c = min_c && (now.hour >= 5'd23);
    nxt.sec  = sec_c  ? 6'd0 : now.sec + 6'd1;
    nxt.min  = sec_c  ? (min_c ? 6'd0 : now.min + 6'd1) : now.min;
    nxt.hour = min_c  ? (hour_c ? 5'd0 : now.hour + 5'd1) : now.hour;
    nxt.day  = hour_c ? now.day + 9'd1 : now.day;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= '0;
    end else if (tick) begin
      now <= nxt;
    end else begin
      if (wr_hm) begin
        now.hour <= wdata[12:8];
        now.min  <= wdata[5:0];
      end
      if (wr_sec) now.sec <= wdata[5:0];
      if (wr_day) now.day <= wdata[8:0];
    end
  end
endmodule

// File: rtl/rtk_match.sv
module rtk_match
  import rtk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  tod_t now,
  input  tod_t alm,
  output logic sec_pulse,
  output logic hit
);
  logic tick_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_d <= 1'b0;
    else        tick_d <= tick;
  end

  assign sec_pulse = tick_d;
  assign hit       = tick_d && (now == alm);
endmodule

// File: rtl/rtk_top.sv
module rtk_top
  import rtk_pkg::*;
#(
  parameter int DIV_A = 32768,
  parameter int DIV_B = 32000,
  parameter int DIV_C = 38400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sec_tick,
  output logic        alarm_hit,
  output logic [15:0] irq_status,
  output logic [15:0] irq_enable
);
  logic       ctl_en;
  logic [1:0] ctl_sel;
  tod_t       alm;
  tod_t       now;
  logic [15:0] ien;
  logic       st_alarm, st_sec;
  logic       tick;

  logic wr_hm, wr_sec, wr_day, wr_ahm, wr_asec, wr_aday, wr_ctl, wr_st, wr_ien, twr;

  assign wr_hm   = reg_we && (reg_addr == OFF_HM);
  assign wr_sec  = reg_we && (reg_addr == OFF_SEC);
  assign wr_day  = reg_we && (reg_addr == OFF_DAY);
  assign wr_ahm  = reg_we && (reg_addr == OFF_AHM);
  assign wr_asec = reg_we && (reg_addr == OFF_ASEC);
  assign wr_aday = reg_we && (reg_addr == OFF_ADAY);
  assign wr_ctl  = reg_we && (reg_addr == OFF_CTL);
  assign wr_st   = reg_we && (reg_addr == OFF_STAT);
  assign wr_ien  = reg_we && (reg_addr == OFF_IEN);
  assign twr     = wr_hm || wr_sec || wr_day;

  rtk_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .sel(ctl_sel), .clr(twr), .tick(tick)
  );

  rtk_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_hm(wr_hm), .wr_sec(wr_sec), .wr_day(wr_day),
    .wdata(reg_wdata), .now(now)
  );

  rtk_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .now(now), .alm(alm),
    .sec_pulse(sec_tick), .hit(alarm_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_sel  <= 2'b00;
      alm      <= '0;
      ien      <= '0;
      st_alarm <= 1'b0;
      st_sec   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_en  <= reg_wdata[CTL_EN_BIT];
        ctl_sel <= reg_wdata[CTL_SEL_LSB +: 2];
      end
      if (wr_ahm) begin
        alm.hour <= reg_wdata[12:8];
        alm.min  <= reg_wdata[5:0];
      end
      if (wr_asec) alm.sec <= reg_wdata[5:0];
      if (wr_aday) alm.day <= reg_wdata[8:0];
      if (wr_ien)  ien     <= reg_wdata;
      st_alarm <= alarm_hit || (st_alarm && !(wr_st && reg_wdata[ST_ALARM_BIT]));
      st_sec   <= sec_tick  || (st_sec   && !(wr_st && reg_wdata[ST_SEC_BIT]));
    end
  end

  always_comb begin
    irq_status = '0;
    irq_status[ST_ALARM_BIT] = st_alarm;
    irq_status[ST_SEC_BIT]   = st_sec;
  end
  assign irq_enable = ien;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_HM:   reg_rdata = {3'b0, now.hour, 2'b0, now.min};
      OFF_SEC:  reg_rdata = {10'b0, now.sec};
      OFF_DAY:  reg_rdata = {7'b0, now.day};
      OFF_AHM:  reg_rdata = {3'b0, alm.hour, 2'b0, alm.min};
      OFF_ASEC: reg_rdata = {10'b0, alm.sec};
      OFF_ADAY: reg_rdata = {7'b0, alm.day};
      OFF_CTL:  reg_rdata = {8'b0, ctl_en, ctl_sel, 5'b0};
      OFF_STAT: reg_rdata = irq_status;
      OFF_IEN:  reg_rdata = ien;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtk_checker.sv
module rtk_checker
  import rtk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        twr,
  input logic        en,
  input logic        sec_tick,
  input logic        alarm_hit,
  input logic [15:0] st,
  input tod_t        now,
  input logic        we,
  input logic [5:0]  addr,
  input logic [15:0] wdata
);
  a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !twr) |=> $stable(now));

  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && now.sec >= 6'd59) |=> (now.sec == 6'd0));

  a_r7_write_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
    twr |-> !tick);

  a_r10_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(en));

  a_r8_hit_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(tick));

  a_r8_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> !alarm_hit);

  a_r9_alarm_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[ST_ALARM_BIT]) |-> $past(alarm_hit));

  a_r3_enable_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_CTL) |=> (en == $past(wdata[CTL_EN_BIT])));
endmodule

bind rtk_top rtk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .twr(twr), .en(ctl_en),
  .sec_tick(sec_tick), .alarm_hit(alarm_hit), .st(irq_status), .now(now),
  .we(reg_we), .addr(reg_addr), .wdata(reg_wdata)
);

// File: tb/sim_rtk_top.sv
module sim_rtk_top;
  localparam int CLK_P = 10;
  localparam int DA = 5;
  localparam int DB = 4;
  localparam int DC = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sec_tick, alarm_hit;
  logic [15:0] irq_status, irq_enable;

  int checks = 0;
  int failures = 0;

  rtk_top #(.DIV_A(DA), .DIV_B(DB), .DIV_C(DC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .alarm_hit(alarm_hit), .irq_status(irq_status), .irq_enable(irq_enable)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  function automatic int lim_of(input int sel);
    if (sel == 1) return DB;
    if (sel == 2) return DC;
    return DA;
  endfunction

  task automatic run_case(input int d, input int h, input int m, input int s,
                          input int sel, input int n);
    int lim, bad, tot, v, ed, eh, em, es;
    lim = lim_of(sel);
    wr(6'h10, 16'h0000);
    wr(6'h20, 16'(d));
    wr(6'h04, 16'(s));
    wr(6'h00, 16'((h << 8) | m));
    wr(6'h10, 16'(32'h80 | (sel << 5)));
    bad = 0;
    for (int k = 1; k <= n * lim; k++) begin
      @(negedge clk);
      if (sec_tick !== ((k % lim) == 0)) bad++;
    end
    tot = (((d * 24 + h) * 60 + m) * 60 + s + n) % (512 * 86400);
    es = tot % 60; em = (tot / 60) % 60; eh = (tot / 3600) % 24; ed = tot / 86400;
    rd(6'h04, v); chk("R4/R5 seconds", v, es);
    rd(6'h00, v); chk("R5 hour/minute", v, (eh << 8) | em);
    rd(6'h20, v); chk("R5 day", v, ed);
    chk("R10 sec_tick timing mismatches", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, hits, hitpos, bad;
    int offs[9] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h20, 'h24};
    int cd[6] = '{0, 0, 0, 0, 511, 10};
    int ch[6] = '{0, 0, 0, 23, 23, 5};
    int cm[6] = '{0, 0, 59, 59, 59, 30};
    int cs[6] = '{0, 57, 58, 59, 58, 0};
    int cn[6] = '{3, 4, 3, 2, 3, 1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 9; i++) begin
      rd(6'(offs[i]), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset sec_tick", int'(sec_tick), 0);
    chk("R1 reset alarm_hit", int'(alarm_hit), 0);

    // R3 control readback
    wr(6'h10, 16'h0040); rd(6'h10, v); chk("R3 control sel=10 disabled", v, 'h40);
    wr(6'h10, 16'hFFFF); rd(6'h10, v); chk("R3 control only bits 7:5", v, 'hE0);
    wr(6'h10, 16'h0000);

    // R2 readback with block disabled
    wr(6'h00, 16'h1729); rd(6'h00, v); chk("R2 hour/minute readback", v, 'h1729);
    wr(6'h04, 16'd42);   rd(6'h04, v); chk("R2 seconds readback", v, 42);
    wr(6'h20, 16'd300);  rd(6'h20, v); chk("R2 day readback", v, 300);
    wr(6'h18, 16'hA5C3); rd(6'h18, v); chk("R2 enable readback", v, 'hA5C3);
    chk("R2 irq_enable pin", int'(irq_enable), 'hA5C3);
    wr(6'h1C, 16'hFFFF); rd(6'h1C, v); chk("R2 unmapped reads 0", v, 0);
    rd(6'h18, v); chk("R2 unmapped write ignored", v, 'hA5C3);
    rd(6'h00, v); chk("R2 unmapped write leaves time", v, 'h1729);

    // R6 disabled hold
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (sec_tick) bad++;
    end
    rd(6'h04, v); chk("R6 disabled seconds hold", v, 42);
    chk("R6 no tick while disabled", bad, 0);

    // R4 R5 R10 sweep over select codes and carry boundaries
    for (int sel = 0; sel < 4; sel++)
      for (int c = 0; c < 6; c++)
        run_case(cd[c], ch[c], cm[c], cs[c], sel, cn[c]);

    // R8 R9 alarm
    wr(6'h10, 16'h0000);
    wr(6'h24, 16'd2); wr(6'h0C, 16'd7); wr(6'h08, 16'h0304);
    wr(6'h20, 16'd2); wr(6'h04, 16'd4); wr(6'h00, 16'h0304);
    wr(6'h14, 16'hFFFF);
    rd(6'h14, v); chk("R9 status cleared", v, 0);
    rd(6'h08, v); chk("R2 alarm hour/minute readback", v, 'h0304);
    rd(6'h0C, v); chk("R2 alarm seconds readback", v, 7);
    rd(6'h24, v); chk("R2 alarm day readback", v, 2);
    wr(6'h10, 16'h0080);
    hits = 0; hitpos = -1;
    for (int k = 1; k <= 5 * DA; k++) begin
      @(negedge clk);
      if (alarm_hit) begin hits++; hitpos = k; end
    end
    chk("R8 single alarm pulse", hits, 1);
    chk("R8 alarm pulse cycle", hitpos, 3 * DA);
    rd(6'h14, v); chk("R9 status alarm+second", v, 'h14);
    chk("R9 irq_status pin", int'(irq_status), 'h14);
    wr(6'h10, 16'h0000);
    wr(6'h14, 16'h0004); rd(6'h14, v); chk("R9 clear alarm only", v, 'h10);
    wr(6'h14, 16'h0010); rd(6'h14, v); chk("R9 clear second", v, 0);

    // R7 R8 write equal to alarm: no pulse; prescaler restart
    wr(6'h10, 16'h0080);
    wr(6'h04, 16'd7);
    hits = 0;
    for (int k = 1; k < DA; k++) begin
      @(negedge clk);
      if (alarm_hit || sec_tick) hits++;
    end
    chk("R8 no pulse from write equality", hits, 0);
    rd(6'h04, v); chk("R7 second not yet elapsed", v, 7);
    @(negedge clk);
    rd(6'h04, v); chk("R7 full period after write", v, 8);
    chk("R10 sec_tick at period end", int'(sec_tick), 1);
    chk("R8 no alarm on non-equal", int'(alarm_hit), 0);
    wr(6'h10, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule